// File: doc/BRIEF.md
# Three-Port Parallel I/O Interface

This block gives a processor 24 general-purpose I/O lines grouped as three byte-wide ports, called A, B and C. The processor reaches the block through a small register window: a chip select, read and write strobes, two address bits and a byte-wide data path. On a device pad the data path is a tri-state bus; inside the chip it is split into an input byte, an output byte and a drive enable. A write-only control register sets, for each group, whether its lines drive or sense. Port A and port B each have one direction bit. Port C has one direction bit for its low nibble and one for its high nibble.

One control bit switches port A to a strobed input mode. In this mode three lines of port C become handshake lines for port A. The device raises a data-ready line once its byte is valid. On that rising edge the block captures the byte and raises an interrupt request toward the system interrupt controller. When the processor reads port A, the interrupt request drops and an acknowledge line pulses, which tells the device it may clear or replace the data on its lines.

All state is held in flip-flops behind a synchronous active-high reset. Port outputs, output enables and read data are simple selections among those registers.

Top module: `tpp_parallel_io`

## Requirements
- R1: After reset every port line is an input, so all output enables are low. All output latches, the interrupt request and the acknowledge are 0, and the data bus is not driven.
- R2: An access happens only while `cs` is high together with `rd` or `wr`. Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register. When `rd` and `wr` are both high the cycle is a write, and the bus is not driven.
- R3: A write to a port loads that port's output latch at the clock edge, whatever the port's direction. Control bits are as follows, with 1 meaning output: bit 0 is port A, bit 1 is port B, bit 2 is port C bits 3:0, and bit 3 is port C bits 7:4. A port drives its latch on its pins and sets its output enables according to these bits.
- R4: A read of a port, or of a port C nibble, set as input returns the pin values sampled at the previous clock edge. If it is set as output, the read returns its latch.
- R5: The control register is write-only. A read at address 3 leaves `cpu_doe` low and `cpu_dout` at 0.
- R6: `cpu_doe` is high exactly in the cycles where `cs` and `rd` are high, `wr` is low and the address is 0, 1 or 2. Outside those cycles `cpu_dout` is 0.
- R7: Control bit 4 selects strobed mode. In this mode port A is input-only. Port C bit 4 becomes the data-ready input. Bit 3 becomes the interrupt-request output and bit 5 the acknowledge output. These override the port C nibble direction bits.
- R8: In strobed mode, a clock edge that sees data-ready high after a low sample captures `pa_in` into a holding register and sets the interrupt request. Reads of port A then return the held byte, whatever the port A pins do afterwards.
- R9: In strobed mode, a read of port A clears the interrupt request at that edge. It also drives acknowledge high for the one following clock per read cycle.
- R10: If a data-ready rise and a port A read fall in the same cycle, the read returns the previous held byte. The new byte is captured, and the interrupt request stays set.
- R11: Leaving strobed mode clears the interrupt request and acknowledge at the first edge after the control write. They stay cleared when strobed mode is entered again without a new data-ready rise.
- R12: In strobed mode a read of port C returns the interrupt request in bit 3, the sampled data-ready line in bit 4 and the acknowledge in bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register select |
| cpu_din | input | 8 | Write data from the processor |
| cpu_dout | output | 8 | Read data to the processor |
| cpu_doe | output | 1 | Read data drive enable |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A pin output |
| pa_oe | output | 8 | Port A per-line output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B pin output |
| pb_oe | output | 8 | Port B per-line output enable |
| pc_in | input | 8 | Port C pin input, bit 4 is data-ready in strobed mode |
| pc_out | output | 8 | Port C pin output, bits 3 and 5 are interrupt request and acknowledge in strobed mode |
| pc_oe | output | 8 | Port C per-line output enable |

## Verification
A wrong direction bit shows up in the output enable pattern of its port in the cycle after the control write. A wrong latch or pin sample shows up on the port pins, or on the next read of that address. A faulty data-ready edge detector or interrupt flag shows up on port C bit 3 one edge after the stimulus. A wrong held byte appears only when port A is next read, so the bench always reads back after each strobe. A missed clear is exposed only by leaving strobed mode and re-entering it, which the bench does explicitly.

// File: rtl/tpp_pkg.sv
package tpp_pkg;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  // Packed MSB first: strobe_a is bit 4, a_out is bit 0.
  typedef struct packed {
    logic strobe_a;
    logic c_hi_out;
    logic c_lo_out;
    logic b_out;
    logic a_out;
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int NUM_SEL  = 4;
  localparam int NUM_PORT = 3;

endpackage

// File: rtl/tpp_decode.sv
module tpp_decode
  import tpp_pkg::*;
(
  input  logic                cs,
  input  logic                rd,
  input  logic                wr,
  input  logic [1:0]          addr,
  output logic [NUM_SEL-1:0]  rd_sel,
  output logic [NUM_SEL-1:0]  wr_sel
);

  logic rd_go;
  logic wr_go;

  // A write strobe takes precedence over a read strobe.
  assign wr_go = cs & wr;
  assign rd_go = cs & rd & ~wr;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assign rd_sel[i] = rd_go && (addr == 2'(i));
    assign wr_sel[i] = wr_go && (addr == 2'(i));
  end

endmodule

// File: rtl/tpp_port_reg.sv
module tpp_port_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] din,
  input  logic [W-1:0] pins,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] pins_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      pins_q  <= '0;
    end else begin
      pins_q <= pins;
      if (wr_en) latch_q <= din;
    end
  end

endmodule

// File: rtl/tpp_strobe.sv
module tpp_strobe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode,
  input  logic         drdy,
  input  logic [W-1:0] port_pins,
  input  logic         rd_a,
  output logic [W-1:0] held_q,
  output logic         irq_q,
  output logic         ack_q
);

  logic drdy_q;
  logic rise;

  assign rise = mode & drdy & ~drdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drdy_q <= 1'b0;
      held_q <= '0;
      irq_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      drdy_q <= drdy;
      ack_q  <= mode & rd_a;
      if (rise) held_q <= port_pins;
      // A new capture wins over a clearing read in the same cycle.
      if (!mode)      irq_q <= 1'b0;
      else if (rise)  irq_q <= 1'b1;
      else if (rd_a)  irq_q <= 1'b0;
    end
  end

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> irq_q);

  // R8
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(held_q));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && rd_a && !rise) |=> !irq_q);

  // R9
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> $past(mode && rd_a));

  // R11
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    !mode |=> (!irq_q && !ack_q));

endmodule

// File: rtl/tpp_parallel_io.sv
module tpp_parallel_io
  import tpp_pkg::*;
#(
  parameter int DW       = 8,
  parameter int IRQ_BIT  = 3,
  parameter int DRDY_BIT = 4,
  parameter int ACK_BIT  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] cpu_din,
  output logic [DW-1:0] cpu_dout,
  output logic          cpu_doe,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);

  localparam int NIB = DW / 2;

  ctrl_t               ctrl_q;
  logic [NUM_SEL-1:0]  rd_sel;
  logic [NUM_SEL-1:0]  wr_sel;
  logic [DW-1:0]       pin_src [NUM_PORT];
  logic [DW-1:0]       latch_q [NUM_PORT];
  logic [DW-1:0]       pins_q  [NUM_PORT];
  logic [DW-1:0]       held_q;
  logic                irq_q;
  logic                ack_q;
  logic [DW-1:0]       a_rd;
  logic [DW-1:0]       b_rd;
  logic [DW-1:0]       c_rd;
  logic [DW-1:0]       c_oe;
  logic [DW-1:0]       c_drv;

  tpp_decode u_dec (
    .cs     (cs),
    .rd     (rd),
    .wr     (wr),
    .addr   (addr),
    .rd_sel (rd_sel),
    .wr_sel (wr_sel)
  );

  assign pin_src[0] = pa_in;
  assign pin_src[1] = pb_in;
  assign pin_src[2] = pc_in;

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
    tpp_port_reg #(.W(DW)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_sel[p]),
      .din     (cpu_din),
      .pins    (pin_src[p]),
      .latch_q (latch_q[p]),
      .pins_q  (pins_q[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                   ctrl_q <= '0;
    else if (wr_sel[SEL_CTRL]) ctrl_q <= ctrl_t'(cpu_din[CTRL_W-1:0]);
  end

  tpp_strobe #(.W(DW)) u_stb (
    .clk       (clk),
    .rst       (rst),
    .mode      (ctrl_q.strobe_a),
    .drdy      (pc_in[DRDY_BIT]),
    .port_pins (pa_in),
    .rd_a      (rd_sel[SEL_A]),
    .held_q    (held_q),
    .irq_q     (irq_q),
    .ack_q     (ack_q)
  );

  // Port A and B pin side
  assign pa_out = latch_q[0];
  assign pa_oe  = {DW{ctrl_q.a_out & ~ctrl_q.strobe_a}};
  assign pb_out = latch_q[1];
  assign pb_oe  = {DW{ctrl_q.b_out}};

  // Port C: nibble directions, then handshake overrides
  always_comb begin
    c_oe  = {{(DW-NIB){ctrl_q.c_hi_out}}, {NIB{ctrl_q.c_lo_out}}};
    c_drv = latch_q[2];
    c_rd  = (latch_q[2] & c_oe) | (pins_q[2] & ~c_oe);
    if (ctrl_q.strobe_a) begin
      c_oe[IRQ_BIT]  = 1'b1;
      c_oe[ACK_BIT]  = 1'b1;
      c_oe[DRDY_BIT] = 1'b0;
      c_drv[IRQ_BIT] = irq_q;
      c_drv[ACK_BIT] = ack_q;
      c_rd[IRQ_BIT]  = irq_q;
      c_rd[ACK_BIT]  = ack_q;
      c_rd[DRDY_BIT] = pins_q[2][DRDY_BIT];
    end
  end

  assign pc_out = c_drv;
  assign pc_oe  = c_oe;

  // Read side
  always_comb begin
    if (ctrl_q.strobe_a)   a_rd = held_q;
    else if (ctrl_q.a_out) a_rd = latch_q[0];
    else                   a_rd = pins_q[0];
    b_rd = ctrl_q.b_out ? latch_q[1] : pins_q[1];
  end

  always_comb begin
    cpu_dout = '0;
    unique case (1'b1)
      rd_sel[SEL_A]: cpu_dout = a_rd;
      rd_sel[SEL_B]: cpu_dout = b_rd;
      rd_sel[SEL_C]: cpu_dout = c_rd;
      default:       cpu_dout = '0;
    endcase
  end

  assign cpu_doe = rd_sel[SEL_A] | rd_sel[SEL_B] | rd_sel[SEL_C];

  // R5
  ctrl_read_float_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && !wr && addr == 2'd3) |-> (!cpu_doe && cpu_dout == '0));

  // R6
  doe_only_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_doe |-> (cs && rd && !wr && addr != 2'd3));

  // R7
  strobe_dir_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.strobe_a |-> (pa_oe == '0 && !pc_oe[DRDY_BIT]
                         && pc_oe[IRQ_BIT] && pc_oe[ACK_BIT]));

  // R3
  latch_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd1) |=> (pb_out == $past(cpu_din)));

endmodule

// File: tb/tpp_parallel_io_test.sv
module tpp_parallel_io_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] cpu_din = 8'h00;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] cpu_dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic       cpu_doe;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // 50 MHz: 20 ns period
  always #10 clk = ~clk;

  tpp_parallel_io uut (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .cpu_din(cpu_din), .cpu_dout(cpu_dout), .cpu_doe(cpu_doe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state
  logic [4:0] m_ctrl;
  logic [7:0] m_la, m_lb, m_lc, m_ia, m_ib, m_ic, m_held;
  bit         m_irq, m_ack, m_dq;

  always @(posedge clk) begin : model
    bit s, rda, rise;
    if (rst) begin
      m_ctrl = 0; m_la = 0; m_lb = 0; m_lc = 0;
      m_ia = 0; m_ib = 0; m_ic = 0; m_held = 0;
      m_irq = 0; m_ack = 0; m_dq = 0;
    end else begin
      s    = m_ctrl[4];
      rda  = cs && rd && !wr && addr == 2'd0;
      rise = s && pc_in[4] && !m_dq;
      if (!s)        m_irq = 0;
      else if (rise) m_irq = 1;
      else if (rda)  m_irq = 0;
      m_ack = s && rda;
      if (rise) m_held = pa_in;
      m_dq = pc_in[4];
      m_ia = pa_in; m_ib = pb_in; m_ic = pc_in;
      if (cs && wr) begin
        case (addr)
          2'd0: m_la = cpu_din;
          2'd1: m_lb = cpu_din;
          2'd2: m_lc = cpu_din;
          default: m_ctrl = cpu_din[4:0];
        endcase
      end
    end
  end

  function automatic logic [7:0] e_pc_oe();
    logic [7:0] v = {{4{m_ctrl[3]}}, {4{m_ctrl[2]}}};
    if (m_ctrl[4]) begin v[3] = 1; v[5] = 1; v[4] = 0; end
    return v;
  endfunction

  function automatic logic [7:0] e_pc_out();
    logic [7:0] v = m_lc;
    if (m_ctrl[4]) begin v[3] = m_irq; v[5] = m_ack; end
    return v;
  endfunction

  function automatic bit e_doe();
    return cs && rd && !wr && addr != 2'd3;
  endfunction

  function automatic logic [7:0] e_dout();
    logic [7:0] v;
    if (!e_doe()) return 8'h00;
    case (addr)
      2'd0: v = m_ctrl[4] ? m_held : (m_ctrl[0] ? m_la : m_ia);
      2'd1: v = m_ctrl[1] ? m_lb : m_ib;
      default: begin
        v[3:0] = m_ctrl[2] ? m_lc[3:0] : m_ic[3:0];
        v[7:4] = m_ctrl[3] ? m_lc[7:4] : m_ic[7:4];
        if (m_ctrl[4]) begin v[3] = m_irq; v[4] = m_ic[4]; v[5] = m_ack; end
      end
    endcase
    return v;
  endfunction

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 pa_out", pa_out, m_la);
      chk("R3 pb_out", pb_out, m_lb);
      chk("R7 pa_oe", pa_oe, (m_ctrl[0] && !m_ctrl[4]) ? 8'hFF : 8'h00);
      chk("R3 pb_oe", pb_oe, m_ctrl[1] ? 8'hFF : 8'h00);
      chk("R7 pc_oe", pc_oe, e_pc_oe());
      chk("R8 pc_out", pc_out, e_pc_out());
      chk("R6 cpu_doe", cpu_doe, e_doe());
      chk("R4 cpu_dout", cpu_dout, e_dout());
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic wr_op(input logic [1:0] a, input logic [7:0] d);
    cs = 1; wr = 1; addr = a; cpu_din = d;
    step(1);
    cs = 0; wr = 0; cpu_din = 8'h00;
  endtask

  task automatic rd_op(input logic [1:0] a, output logic [7:0] v, output logic oe);
    cs = 1; rd = 1; addr = a;
    @(negedge clk);
    v = cpu_dout; oe = cpu_doe;
    step(1);
    cs = 0; rd = 0;
  endtask

  initial begin : watchdog
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    logic       oe;
    step(3);
    rst = 0;
    step(1);
    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 pc_out", pc_out, 8'h00);
    chk("R1 doe", cpu_doe, 1'b0);

    // R4 input reads, R2 decode
    pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
    step(1);
    rd_op(2'd0, v, oe); chk("R4 read A pins", v, 8'h5A);
    rd_op(2'd1, v, oe); chk("R2 read B pins", v, 8'hC3);
    rd_op(2'd2, v, oe); chk("R2 read C pins", v, 8'h96);

    // R3 outputs
    wr_op(2'd3, 8'h0F);
    wr_op(2'd0, 8'h11);
    wr_op(2'd1, 8'h22);
    wr_op(2'd2, 8'h3C);
    chk("R3 pa_out", pa_out, 8'h11);
    chk("R3 pa_oe", pa_oe, 8'hFF);
    chk("R3 pc_out", pc_out, 8'h3C);
    rd_op(2'd0, v, oe); chk("R4 read A latch", v, 8'h11);

    // R5 control is write-only
    rd_op(2'd3, v, oe); chk("R5 ctrl read doe", oe, 1'b0);
    chk("R5 ctrl read data", v, 8'h00);

    // R2 no select, and read+write together
    rd = 1; addr = 2'd0;
    @(negedge clk); chk("R2 no cs doe", cpu_doe, 1'b0);
    step(1); rd = 0;
    cs = 1; rd = 1; wr = 1; addr = 2'd1; cpu_din = 8'h77;
    @(negedge clk); chk("R2 rd+wr doe", cpu_doe, 1'b0);
    step(1); cs = 0; rd = 0; wr = 0;
    chk("R2 rd+wr is write", pb_out, 8'h77);

    // R3 mixed directions
    wr_op(2'd3, 8'h05);
    chk("R3 mixed pc_oe", pc_oe, 8'h0F);
    chk("R3 mixed pb_oe", pb_oe, 8'h00);
    pc_in = 8'hA0;
    step(1);
    rd_op(2'd2, v, oe); chk("R4 C nibble mix", v, 8'hAC);

    // R7 strobed mode
    pc_in = 8'h00;
    wr_op(2'd3, 8'h10);
    chk("R7 pc_oe strobe", pc_oe, 8'h28);
    chk("R7 pa_oe strobe", pa_oe, 8'h00);

    // R8 capture
    pa_in = 8'hA7; pc_in = 8'h10;
    step(1);
    chk("R8 irq set", pc_out[3], 1'b1);
    pa_in = 8'h00;
    step(1);
    rd_op(2'd0, v, oe); chk("R8 held byte", v, 8'hA7);
    chk("R9 irq cleared", pc_out[3], 1'b0);
    chk("R9 ack high", pc_out[5], 1'b1);
    step(1);
    chk("R9 ack one clock", pc_out[5], 1'b0);

    // R10 rise and read together
    pc_in = 8'h00; step(1);
    pa_in = 8'h3E; pc_in = 8'h10;
    rd_op(2'd0, v, oe); chk("R10 old byte", v, 8'hA7);
    chk("R10 irq kept", pc_out[3], 1'b1);
    rd_op(2'd0, v, oe); chk("R10 new byte", v, 8'h3E);

    // R12 port C readback, R11 mode exit
    pc_in = 8'h00; step(1);
    pa_in = 8'h44; pc_in = 8'h10; step(1);
    step(1);
    rd_op(2'd2, v, oe); chk("R12 C handshake bits", v & 8'h38, 8'h18);
    wr_op(2'd3, 8'h00);
    step(1);
    wr_op(2'd3, 8'h10);
    chk("R11 irq stays clear", pc_out[3], 1'b0);
    chk("R11 ack clear", pc_out[5], 1'b0);
    rd_op(2'd0, v, oe); chk("R8 held kept", v, 8'h44);

    step(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule